// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Gating Controller

This block decides which clocks keep running while a processor sits in one of three low-power states: sleep, stop and standby. Software picks a state with a one-cycle request strobe. A wake event brings the block back to run. From the current state the block drives two enables, one for the free-running core clock and one for the bus clock. It also drives a select that chooses between the internal RC oscillator and the configured system clock, and a request for a system reset. The oscillators, PLL, crystal and power switches are modelled only as the enable and select lines that control them.

A small control word, reachable over a 32-bit bus, holds one debug override per low-power state. When an override is set, both clocks keep running through that state, so a debugger can stay attached. Leaving stop or standby always puts the clock configuration (the PLL and crystal enables) back to its reset state, whatever the override says. Leaving sleep keeps the configuration. The control word and a sticky standby-wake flag are cleared only by power-on reset, so both survive the system reset that standby produces.

Top module: `pm_dbg_clkgate`

## Requirements
- R1: The control word is written only when `bus_we` is high and `bus_size` is 2'b10 (word). A write of any other size leaves `bus_rdata` unchanged.
- R2: In the control word, bit 0 is the sleep override, bit 1 the stop override and bit 2 the standby override. Software can write and read back all three. Bits 31:3 always read as zero, whatever was written to them.
- R3: Power-on reset (`por_n` low) clears the control word and `stby_flag`. System reset (`sys_rst_n` low) leaves both unchanged, returns the block to run and clears the PLL and crystal enables.
- R4: In run, `fclk_en` and `hclk_en` are both 1. `src_rc` is 1 exactly when `pll_en` and `xtal_en` are both 0.
- R5: In sleep with the sleep override clear, `fclk_en`=1 and `hclk_en`=0. With it set, both are 1. In both cases `src_rc` keeps its run value. A change to the override during sleep shows on `hclk_en` one edge later.
- R6: On wake from sleep, `pll_en` and `xtal_en` keep their values from before sleep.
- R7: In stop, `fclk_en` and `hclk_en` both equal the stop override, and `src_rc`=1.
- R8: On wake from stop, `pll_en` and `xtal_en` are cleared, whatever the override value.
- R9: In standby with the standby override clear, both enables are 0 and `sys_rst_req` is 0. The edge that takes a wake from standby raises `sys_rst_req` for exactly one cycle and clears `pll_en` and `xtal_en`.
- R10: In standby with the standby override set, both enables are 1, `src_rc`=1, and `sys_rst_req` stays 1 for the whole of standby.
- R11: `stby_flag` becomes 1 at the edge that takes a wake from standby. After that it stays 1 until power-on reset.
- R12: `mode_req` is encoded as 00 none, 01 sleep, 10 stop and 11 standby. All outputs are registered. A `mode_go` in run changes the outputs at the next edge. While not in run, `mode_go` and `cfg_we` are ignored. In run, `wake` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the currently selected source |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Asynchronous system reset, active low |
| bus_we | input | 1 | Control word write strobe |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| bus_wdata | input | 32 | Control word write data |
| bus_rdata | output | 32 | Control word read data |
| cfg_we | input | 1 | Load clock configuration (run only) |
| cfg_pll | input | 1 | PLL enable value to load |
| cfg_xtal | input | 1 | Crystal enable value to load |
| mode_go | input | 1 | Low-power request strobe |
| mode_req | input | 2 | Requested state |
| wake | input | 1 | Wake event |
| fclk_en | output | 1 | Core clock enable |
| hclk_en | output | 1 | Bus clock enable |
| src_rc | output | 1 | 1: internal RC oscillator, 0: configured system clock |
| pll_en | output | 1 | PLL enable |
| xtal_en | output | 1 | Crystal enable |
| sys_rst_req | output | 1 | System reset request |
| stby_flag | output | 1 | Sticky standby-wake flag |

## Verification
The block has no parameters, so the bench builds its only configuration, and that configuration is small enough to sweep in full. It covers every combination of the three overrides, every PLL and crystal setting, and every low-power state. Each state is visited, checked, then left through wake while the configuration is checked. The bench separately tests partial-size writes, reserved bits, an override change in the middle of sleep, and the contrast between system reset and power-on reset on the control word and the sticky flag.

// File: rtl/pm_dbg_clkgate.sv
module pm_dbg_clkgate (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        cfg_we,
  input  logic        cfg_pll,
  input  logic        cfg_xtal,
  input  logic        mode_go,
  input  logic [1:0]  mode_req,
  input  logic        wake,
  output logic        fclk_en,
  output logic        hclk_en,
  output logic        src_rc,
  output logic        pll_en,
  output logic        xtal_en,
  output logic        sys_rst_req,
  output logic        stby_flag
);
  localparam logic [1:0] M_RUN   = 2'd0;
  localparam logic [1:0] M_SLEEP = 2'd1;
  localparam logic [1:0] M_STOP  = 2'd2;
  localparam logic [1:0] M_STBY  = 2'd3;
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [2:0] ovr_q, ovr_d;
  logic [1:0] mode_q, mode_d;
  logic       pll_d, xtal_d, fclk_d, hclk_d, src_d, rst_d, leave_lp;

  assign ovr_d     = (bus_we && bus_size == SZ_WORD) ? bus_wdata[2:0] : ovr_q;
  assign bus_rdata = {29'd0, ovr_q};
  assign leave_lp  = (mode_q != M_RUN) && wake;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == M_RUN) begin
      if (mode_go) mode_d = mode_req;
    end else if (wake) begin
      mode_d = M_RUN;
    end
  end

  always_comb begin
    pll_d  = pll_en;
    xtal_d = xtal_en;
    if (mode_q == M_RUN && cfg_we) begin
      pll_d  = cfg_pll;
      xtal_d = cfg_xtal;
    end
    if (leave_lp && mode_q != M_SLEEP) begin
      pll_d  = 1'b0;
      xtal_d = 1'b0;
    end
  end

  always_comb begin
    case (mode_d)
      M_SLEEP: begin fclk_d = 1'b1;     hclk_d = ovr_d[0]; src_d = !(pll_d || xtal_d); end
      M_STOP:  begin fclk_d = ovr_d[1]; hclk_d = ovr_d[1]; src_d = 1'b1;               end
      M_STBY:  begin fclk_d = ovr_d[2]; hclk_d = ovr_d[2]; src_d = 1'b1;               end
      default: begin fclk_d = 1'b1;     hclk_d = 1'b1;     src_d = !(pll_d || xtal_d); end
    endcase
  end

  assign rst_d = (mode_d == M_STBY && ovr_d[2]) || (mode_q == M_STBY && wake);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ovr_q     <= '0;
      stby_flag <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      if (mode_q == M_STBY && wake) stby_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n or negedge sys_rst_n) begin
    if (!por_n || !sys_rst_n) begin
      mode_q      <= M_RUN;
      pll_en      <= 1'b0;
      xtal_en     <= 1'b0;
      fclk_en     <= 1'b1;
      hclk_en     <= 1'b1;
      src_rc      <= 1'b1;
      sys_rst_req <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      pll_en      <= pll_d;
      xtal_en     <= xtal_d;
      fclk_en     <= fclk_d;
      hclk_en     <= hclk_d;
      src_rc      <= src_d;
      sys_rst_req <= rst_d;
    end
  end
endmodule

module pm_dbg_clkgate_chk (
  input logic        clk,
  input logic        por_n,
  input logic        sys_rst_n,
  input logic        bus_we,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_rdata,
  input logic        wake,
  input logic [1:0]  mode_q,
  input logic        fclk_en,
  input logic        hclk_en,
  input logic        src_rc,
  input logic        pll_en,
  input logic        xtal_en,
  input logic        sys_rst_req,
  input logic        stby_flag
);
  p_part_write_ignored_r1: assert property (@(posedge clk) disable iff (!por_n)
    (bus_we && bus_size != 2'b10) |=> $stable(bus_rdata));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[31:3] == 29'd0);

  p_sysrst_keeps_ctl_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !(bus_we && bus_size == 2'b10)) |=> $stable(bus_rdata));

  p_run_src_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (mode_q == 2'd0) |-> (fclk_en && hclk_en && (src_rc == !(pll_en || xtal_en))));

  p_hclk_needs_fclk_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    hclk_en |-> fclk_en);

  p_stop_gated_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (mode_q == 2'd2) |-> (src_rc && fclk_en == bus_rdata[1] && hclk_en == bus_rdata[1]));

  p_stop_exit_cfg_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (mode_q == 2'd2 && wake) |=> (!pll_en && !xtal_en));

  p_stby_wake_rst_r9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (mode_q == 2'd3 && wake) |=> (sys_rst_req && !pll_en && !xtal_en));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
    stby_flag |=> stby_flag);
endmodule

bind pm_dbg_clkgate pm_dbg_clkgate_chk u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_we(bus_we), .bus_size(bus_size),
  .bus_rdata(bus_rdata), .wake(wake), .mode_q(mode_q), .fclk_en(fclk_en), .hclk_en(hclk_en),
  .src_rc(src_rc), .pll_en(pll_en), .xtal_en(xtal_en), .sys_rst_req(sys_rst_req),
  .stby_flag(stby_flag)
);

// File: tb/pm_dbg_clkgate_bench.sv
`timescale 1ns/1ps
module pm_dbg_clkgate_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_we = 1'b0, cfg_pll = 1'b0, cfg_xtal = 1'b0;
  logic        mode_go = 1'b0, wake = 1'b0;
  logic [1:0]  mode_req = 2'b00;
  logic        fclk_en, hclk_en, src_rc, pll_en, xtal_en, sys_rst_req, stby_flag;

  int n_chk = 0, n_bad = 0;
  logic exp_flag = 1'b0;

  always #4 clk = ~clk;

  pm_dbg_clkgate u_pm_dbg_clkgate (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_we(bus_we), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_pll(cfg_pll),
    .cfg_xtal(cfg_xtal), .mode_go(mode_go), .mode_req(mode_req), .wake(wake),
    .fclk_en(fclk_en), .hclk_en(hclk_en), .src_rc(src_rc), .pll_en(pll_en),
    .xtal_en(xtal_en), .sys_rst_req(sys_rst_req), .stby_flag(stby_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_we = 0; cfg_we = 0; mode_go = 0; wake = 0; bus_size = 2'b00;
  endtask

  // {fclk, hclk, src, pll, xtal, rst}
  function automatic logic [5:0] outs();
    return {fclk_en, hclk_en, src_rc, pll_en, xtal_en, sys_rst_req};
  endfunction

  task automatic wr_ctl(input logic [1:0] sz, input logic [31:0] d);
    bus_we = 1; bus_size = sz; bus_wdata = d; cyc(); idle();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [5:0] snap;
    cyc(); cyc();
    check("R3 por ctl", bus_rdata, 32'd0);
    por_n = 1; cyc(); sys_rst_n = 1; cyc();
    check("R4 reset outs", {26'd0, outs()}, {26'd0, 6'b111000});
    check("R3 por flag", {31'd0, stby_flag}, 32'd0);

    wr_ctl(2'b00, 32'hFFFF_FFFF); check("R1 byte write", bus_rdata, 32'd0);
    wr_ctl(2'b01, 32'hFFFF_FFFF); check("R1 half write", bus_rdata, 32'd0);
    wr_ctl(2'b10, 32'hFFFF_FFFF); check("R2 word write", bus_rdata, 32'd7);
    wr_ctl(2'b10, 32'hFFFF_FFF8); check("R2 reserved", bus_rdata, 32'd0);
    wr_ctl(2'b10, 32'h0000_0005); check("R2 bits", bus_rdata, 32'd5);

    for (int ov = 0; ov < 8; ov++) begin
      for (int c = 0; c < 4; c++) begin
        for (int m = 1; m < 4; m++) begin
          logic [5:0] e;
          logic pc, xc, srun, o;
          pc = c[1]; xc = c[0]; srun = (c == 0);
          bus_we = 1; bus_size = 2'b10; bus_wdata = 32'(ov);
          cfg_we = 1; cfg_pll = pc; cfg_xtal = xc;
          cyc(); idle();
          check("R4 run", {26'd0, outs()}, {26'd0, 1'b1, 1'b1, srun, pc, xc, 1'b0});
          check("R2 readback", bus_rdata, 32'(ov));

          wake = 1; cyc(); idle();
          check("R12 wake in run", {26'd0, outs()}, {26'd0, 1'b1, 1'b1, srun, pc, xc, 1'b0});

          mode_go = 1; mode_req = 2'(m); cyc(); idle();
          o = ov[m-1];
          case (m)
            1: e = {1'b1, o, srun, pc, xc, 1'b0};
            2: e = {o, o, 1'b1, pc, xc, 1'b0};
            default: e = {o, o, 1'b1, pc, xc, o};
          endcase
          check(m == 1 ? "R5 sleep" : (m == 2 ? "R7 stop" : (o ? "R10 stby ov" : "R9 stby")),
                {26'd0, outs()}, {26'd0, e});

          cfg_we = 1; cfg_pll = !pc; cfg_xtal = !xc; mode_go = 1; mode_req = 2'(4 - m);
          cyc(); idle();
          check("R12 ignored in lp", {26'd0, outs()}, {26'd0, e});

          wake = 1; cyc(); idle();
          if (m == 3) exp_flag = 1'b1;
          if (m == 1)
            check("R6 sleep keeps cfg", {26'd0, outs()}, {26'd0, 1'b1, 1'b1, srun, pc, xc, 1'b0});
          else if (m == 2)
            check("R8 stop clears cfg", {26'd0, outs()}, {26'd0, 6'b111000});
          else
            check("R9 stby wake rst", {26'd0, outs()}, {26'd0, 6'b111001});
          check("R11 flag", {31'd0, stby_flag}, {31'd0, exp_flag});
          cyc();
          check("R9 rst one cycle", {31'd0, sys_rst_req}, 32'd0);
        end
      end
    end

    wr_ctl(2'b10, 32'd0);
    mode_go = 1; mode_req = 2'b01; cyc(); idle();
    check("R5 sleep gated", {30'd0, fclk_en, hclk_en}, 32'd2);
    wr_ctl(2'b10, 32'd1);
    check("R5 mid-sleep override", {30'd0, fclk_en, hclk_en}, 32'd3);
    wr_ctl(2'b10, 32'd0);
    check("R5 mid-sleep clear", {30'd0, fclk_en, hclk_en}, 32'd2);
    wake = 1; cyc(); idle();

    wr_ctl(2'b10, 32'd6);
    cfg_we = 1; cfg_pll = 1; cfg_xtal = 1; cyc(); idle();
    snap = outs();
    check("R4 cfg loaded", {26'd0, snap}, {26'd0, 6'b110110});
    sys_rst_n = 0; cyc();
    check("R3 sysrst ctl", bus_rdata, 32'd6);
    check("R3 sysrst flag", {31'd0, stby_flag}, {31'd0, exp_flag});
    sys_rst_n = 1; cyc();
    check("R3 sysrst outs", {26'd0, outs()}, {26'd0, 6'b111000});
    por_n = 0; cyc();
    check("R3 por clears ctl", bus_rdata, 32'd0);
    check("R11 por clears flag", {31'd0, stby_flag}, 32'd0);
    por_n = 1; cyc();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule